// File: doc/BRIEF.md
# Plane Rotation Unit for Fixed-Point Vector Pairs

This unit takes two vectors, x and y, of signed Q1.15 words and rotates every element pair (x(i), y(i)) by one common angle. The angle is chosen so that the leading element of the rotated y becomes zero. The unit squares and sums the leading pair to form r², then finds the inverse square root of r² with a seeded Newton iteration. Multiplying that scale factor by x(1) gives the cosine, and multiplying it by y(1) gives the sine, so no divider is needed. The same cosine and sine are then applied to every lane. The rotated lanes are v = x·cos + y·sin and w = y·cos − x·sin.

All arithmetic runs through a single shared multiplier, one product per clock. Intermediate values are kept wide enough that none of them overflows. Each final lane result is rounded to nearest and clamped to 16 bits.

Vectors enter on a valid/ready port and leave on a valid/ready port. A pair is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low until the result has been handed over, so the unit accepts nothing while it is busy. The result is presented with `out_valid`. The consumer may hold `out_ready` low for as long as it likes, and during that time the result stays frozen on the port.

Top module: `givrot_unit`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A vector pair is captured only on an edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the next cycle until the result is transferred. Input presented while the unit is busy is ignored, and the result belongs to the pair that was captured.
- R3: `out_valid` rises exactly 5 + 3·NEWTON_STEPS + 4·VEC_LEN cycles after the accepting edge, which is 34 cycles with the defaults. When x(1) = y(1) = 0 it rises 3 cycles after the accepting edge.
- R4: When a result is valid, w(1) lies within ±2 LSB of zero.
- R5: v(1) equals round(sqrt(x(1)² + y(1)²)) in LSB units, within ±3 LSB, clamped to 32767.
- R6: Every lane i satisfies v(i) ≈ x(i)·c + y(i)·s and w(i) ≈ y(i)·c − x(i)·s, within ±3 LSB. Here c = x(1)/r and s = y(1)/r, and the same angle is used for every lane.
- R7: A lane result whose exact value falls outside the 16-bit range is clamped to 32767 or −32768.
- R8: When x(1) = y(1) = 0, the outputs are exactly v = x and w = y.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_v` and `out_w` hold steady. After the transfer edge, `in_ready` is 1.
- R10: Words are two's-complement Q1.15 (value = word / 32768). Lane i occupies bits [16i+15:16i], and lane 0 is the leading element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input vector pair is offered |
| in_ready | output | 1 | Unit is idle and will capture an offered pair |
| in_x | input | 16·VEC_LEN | Vector x, lane 0 in the low bits |
| in_y | input | 16·VEC_LEN | Vector y, lane 0 in the low bits |
| out_valid | output | 1 | Rotated vectors are presented |
| out_ready | input | 1 | Consumer takes the result |
| out_v | output | 16·VEC_LEN | Rotated x lanes |
| out_w | output | 16·VEC_LEN | Rotated y lanes, lane 0 near zero |

## Verification
The checks that run on every cycle cover the handshake and one numeric property:
- `in_ready` and `out_valid` are never high together.
- Acceptance is followed by busy.
- Under back-pressure the output holds steady, and a transfer returns the unit to idle.
- Whenever a result is valid, w(1) sits within 2 LSB of zero.

Only the bench scenarios can show the rest, because it needs a real-valued model of the rotation:
- The exact latency, including the short path for a zero leading pair.
- The accuracy of v(1) against the magnitude r.
- The common-angle rotation of the other lanes.
- The clamping of out-of-range lanes.
- The exact pass-through when the leading pair is zero.
- That input offered while the unit is busy is dropped.

// File: rtl/givrot_pkg.sv
package givrot_pkg;
  localparam int DATA_W = 16;
  localparam int OP_W   = 20;
  localparam int PROD_W = 2 * OP_W;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SQX, ST_SQY, ST_NORM, ST_N1, ST_N2, ST_N3,
    ST_COS, ST_SIN, ST_E0, ST_E1, ST_E2, ST_E3, ST_DONE
  } rot_state_t;

  // round to nearest by sh bits, then clamp to a signed 16-bit word
  function automatic logic signed [DATA_W-1:0] rnd_sat(input logic signed [63:0] a,
                                                       input int sh);
    logic signed [63:0] r;
    r = (a + (64'sd1 <<< (sh - 1))) >>> sh;
    if (r > 64'sd32767) return 16'sh7fff;
    if (r < -64'sd32768) return 16'sh8000;
    return r[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/givrot_mul.sv
module givrot_mul import givrot_pkg::*; (
  input  logic signed [OP_W-1:0]   op_a,
  input  logic signed [OP_W-1:0]   op_b,
  output logic signed [PROD_W-1:0] prod
);
  assign prod = op_a * op_b;
endmodule

// File: rtl/givrot_norm.sv
// Even-shift normalisation of r^2 and a piecewise seed for 1/sqrt(u), u in [1,4).
module givrot_norm (
  input  logic [31:0] r2,
  output logic [4:0]  shift_k,
  output logic [17:0] u_q16,
  output logic [17:0] seed_q16
);
  logic [5:0] lz;

  always_comb begin
    lz = 6'd32;
    for (int j = 0; j < 32; j++) begin
      if (r2[j]) lz = 6'(31 - j);
    end
  end

  assign shift_k = 5'(lz >> 1);
  assign u_q16   = 18'((r2 << {shift_k, 1'b0}) >> 14);

  always_comb begin
    case (u_q16[17:15])
      3'd2:    seed_q16 = 18'd58617;
      3'd3:    seed_q16 = 18'd49539;
      3'd4:    seed_q16 = 18'd43691;
      3'd5:    seed_q16 = 18'd39520;
      3'd6:    seed_q16 = 18'd36353;
      3'd7:    seed_q16 = 18'd33843;
      default: seed_q16 = 18'd65536;
    endcase
  end
endmodule

// File: rtl/givrot_unit.sv
module givrot_unit import givrot_pkg::*; #(
  parameter int VEC_LEN      = 5,
  parameter int NEWTON_STEPS = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [VEC_LEN*DATA_W-1:0] in_x,
  input  logic [VEC_LEN*DATA_W-1:0] in_y,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [VEC_LEN*DATA_W-1:0] out_v,
  output logic [VEC_LEN*DATA_W-1:0] out_w
);
  localparam int IDX_W  = (VEC_LEN > 1) ? $clog2(VEC_LEN) : 1;
  localparam int ITER_W = $clog2(NEWTON_STEPS + 1);

  rot_state_t state;
  logic signed [DATA_W-1:0] xs [VEC_LEN];
  logic signed [DATA_W-1:0] ys [VEC_LEN];
  logic signed [DATA_W-1:0] vq [VEC_LEN];
  logic signed [DATA_W-1:0] wq [VEC_LEN];
  logic [31:0]              r2;
  logic [4:0]               kq;
  logic [17:0]              uq, g;
  logic [OP_W-1:0]          t;
  logic signed [DATA_W-1:0] c, s;
  logic signed [PROD_W-1:0] acc;
  logic [IDX_W-1:0]         idx;
  logic [ITER_W-1:0]        iter;

  logic signed [OP_W-1:0]   op_a, op_b, h;
  logic signed [PROD_W-1:0] p;
  logic [4:0]               nk;
  logic [17:0]              nu, nseed;

  givrot_mul u_mul (.op_a(op_a), .op_b(op_b), .prod(p));
  givrot_norm u_norm (.r2(r2), .shift_k(nk), .u_q16(nu), .seed_q16(nseed));

  assign h = 20'sd196608 - $signed(t);

  always_comb begin
    op_a = '0;
    op_b = '0;
    case (state)
      ST_SQX: begin op_a = OP_W'(xs[0]); op_b = OP_W'(xs[0]); end
      ST_SQY: begin op_a = OP_W'(ys[0]); op_b = OP_W'(ys[0]); end
      ST_N1:  begin op_a = OP_W'(g);     op_b = OP_W'(g);     end
      ST_N2:  begin op_a = OP_W'(uq);    op_b = $signed(t);   end
      ST_N3:  begin op_a = OP_W'(g);     op_b = h;            end
      ST_COS: begin op_a = OP_W'(xs[0]); op_b = OP_W'(g);     end
      ST_SIN: begin op_a = OP_W'(ys[0]); op_b = OP_W'(g);     end
      ST_E0:  begin op_a = OP_W'(xs[idx]); op_b = OP_W'(c);   end
      ST_E1:  begin op_a = OP_W'(ys[idx]); op_b = OP_W'(s);   end
      ST_E2:  begin op_a = OP_W'(ys[idx]); op_b = OP_W'(c);   end
      ST_E3:  begin op_a = OP_W'(xs[idx]); op_b = OP_W'(s);   end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      r2 <= '0; kq <= '0; uq <= '0; g <= '0; t <= '0;
      c <= '0; s <= '0; acc <= '0; idx <= '0; iter <= '0;
      for (int i = 0; i < VEC_LEN; i++) begin
        xs[i] <= '0; ys[i] <= '0; vq[i] <= '0; wq[i] <= '0;
      end
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          for (int i = 0; i < VEC_LEN; i++) begin
            xs[i] <= in_x[i*DATA_W +: DATA_W];
            ys[i] <= in_y[i*DATA_W +: DATA_W];
          end
          state <= ST_SQX;
        end
        ST_SQX: begin r2 <= p[31:0]; state <= ST_SQY; end
        ST_SQY: begin r2 <= r2 + p[31:0]; state <= ST_NORM; end
        ST_NORM: begin
          if (r2 == '0) begin
            for (int i = 0; i < VEC_LEN; i++) begin
              vq[i] <= xs[i]; wq[i] <= ys[i];
            end
            state <= ST_DONE;
          end else begin
            kq <= nk; uq <= nu; g <= nseed; iter <= '0;
            state <= ST_N1;
          end
        end
        ST_N1: begin t <= p[35:16]; state <= ST_N2; end
        ST_N2: begin t <= p[35:16]; state <= ST_N3; end
        ST_N3: begin
          g <= p[34:17];
          iter <= iter + 1'b1;
          state <= (iter == ITER_W'(NEWTON_STEPS - 1)) ? ST_COS : ST_N1;
        end
        ST_COS: begin c <= rnd_sat(64'(p) <<< kq, 16); state <= ST_SIN; end
        ST_SIN: begin s <= rnd_sat(64'(p) <<< kq, 16); idx <= '0; state <= ST_E0; end
        ST_E0: begin acc <= p; state <= ST_E1; end
        ST_E1: begin vq[idx] <= rnd_sat(64'(acc) + 64'(p), 15); state <= ST_E2; end
        ST_E2: begin acc <= p; state <= ST_E3; end
        ST_E3: begin
          wq[idx] <= rnd_sat(64'(acc) - 64'(p), 15);
          if (idx == IDX_W'(VEC_LEN - 1)) begin
            idx <= '0; state <= ST_DONE;
          end else begin
            idx <= idx + 1'b1; state <= ST_E0;
          end
        end
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);

  for (genvar gi = 0; gi < VEC_LEN; gi++) begin : g_lane
    assign out_v[gi*DATA_W +: DATA_W] = vq[gi];
    assign out_w[gi*DATA_W +: DATA_W] = wq[gi];
  end
endmodule

// File: rtl/givrot_chk.sv
module givrot_chk #(
  parameter int VEC_LEN = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [VEC_LEN*16-1:0] out_v,
  input logic [VEC_LEN*16-1:0] out_w
);
  logic signed [15:0] w_lead;
  assign w_lead = out_w[15:0];

  assert_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_v) && $stable(out_w)));

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid));

  assert_lead_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (w_lead <= 16'sd2 && w_lead >= -16'sd2));
endmodule

bind givrot_unit givrot_chk #(.VEC_LEN(VEC_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_v(out_v), .out_w(out_w)
);

// File: tb/givrot_unit_bench.sv
module givrot_unit_bench;
  localparam int VEC_LEN = 5;
  localparam int NEWTON_STEPS = 3;
  localparam int LAT = 5 + 3 * NEWTON_STEPS + 4 * VEC_LEN;
  localparam int W = VEC_LEN * 16;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [W-1:0] in_x = '0, in_y = '0;
  logic in_ready, out_valid;
  logic [W-1:0] out_v, out_w;

  givrot_unit #(.VEC_LEN(VEC_LEN), .NEWTON_STEPS(NEWTON_STEPS)) u_givrot_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .out_valid(out_valid), .out_ready(out_ready),
    .out_v(out_v), .out_w(out_w));

  always #10 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  int ex [VEC_LEN];
  int ey [VEC_LEN];
  int seed_st = 12345;

  // behavioural handshake/timing model, compared every cycle
  bit m_rdy, m_ov;
  int m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rdy <= 1; m_ov <= 0; m_cnt <= 0;
    end else if (m_rdy) begin
      if (in_valid) begin
        m_rdy <= 0;
        m_cnt <= (in_x[15:0] == 16'd0 && in_y[15:0] == 16'd0) ? 3 : LAT;
      end
    end else if (!m_ov) begin
      if (m_cnt == 1) m_ov <= 1;
      m_cnt <= m_cnt - 1;
    end else if (out_ready) begin
      m_ov <= 0; m_rdy <= 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_tests++;
      if (in_ready !== m_rdy || out_valid !== m_ov) begin
        n_fail++;
        $display("FAIL R2 R3 R9 cycle model: in_ready=%b out_valid=%b expected %b %b",
                 in_ready, out_valid, m_rdy, m_ov);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int rnd(input real a);
    return $rtoi($floor(a + 0.5));
  endfunction

  function automatic int clamp(input int a);
    return (a > 32767) ? 32767 : ((a < -32768) ? -32768 : a);
  endfunction

  function automatic int lane(input logic [W-1:0] bus, input int i);
    logic signed [15:0] v;
    v = bus[i*16 +: 16];
    return int'(v);
  endfunction

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  function automatic int next_val();
    seed_st = seed_st * 1103515245 + 12345;
    return int'($signed(seed_st[30:15]));
  endfunction

  task automatic send();
    @(negedge clk);
    for (int i = 0; i < VEC_LEN; i++) begin
      in_x[i*16 +: 16] = 16'(ex[i]);
      in_y[i*16 +: 16] = 16'(ey[i]);
    end
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_out(output int waited);
    waited = 0;
    while (!out_valid && waited < 500) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic check_result(input string tag);
    real xr, yr, r, cs, sn;
    int ev, ew;
    xr = $itor(ex[0]); yr = $itor(ey[0]);
    r = $sqrt(xr * xr + yr * yr);
    if (ex[0] == 0 && ey[0] == 0) begin
      for (int i = 0; i < VEC_LEN; i++) begin
        chk(lane(out_v, i) == ex[i], {"R8 pass v ", tag}, lane(out_v, i), ex[i]);
        chk(lane(out_w, i) == ey[i], {"R8 pass w ", tag}, lane(out_w, i), ey[i]);
      end
      return;
    end
    cs = xr / r; sn = yr / r;
    chk(absd(lane(out_w, 0), 0) <= 2, {"R4 lead w ", tag}, lane(out_w, 0), 0);
    chk(absd(lane(out_v, 0), clamp(rnd(r))) <= 3, {"R5 lead v ", tag},
        lane(out_v, 0), clamp(rnd(r)));
    for (int i = 1; i < VEC_LEN; i++) begin
      ev = rnd($itor(ex[i]) * cs + $itor(ey[i]) * sn);
      ew = rnd($itor(ey[i]) * cs - $itor(ex[i]) * sn);
      chk(absd(lane(out_v, i), clamp(ev)) <= 3,
          (clamp(ev) != ev) ? {"R7 clamp v ", tag} : {"R6 lane v ", tag},
          lane(out_v, i), clamp(ev));
      chk(absd(lane(out_w, i), clamp(ew)) <= 3,
          (clamp(ew) != ew) ? {"R7 clamp w ", tag} : {"R6 lane w ", tag},
          lane(out_w, i), clamp(ew));
    end
  endtask

  task automatic take();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run_case(input string tag);
    int waited, exp_lat;
    exp_lat = (ex[0] == 0 && ey[0] == 0) ? 3 : LAT;
    send();
    wait_out(waited);
    chk(waited == exp_lat, {"R3 latency ", tag}, waited, exp_lat);
    check_result(tag);
    take();
  endtask

  task automatic set5(input int x0, input int x1, input int x2, input int x3, input int x4,
                      input int y0, input int y1, input int y2, input int y3, input int y4);
    ex[0] = x0; ex[1] = x1; ex[2] = x2; ex[3] = x3; ex[4] = x4;
    ey[0] = y0; ey[1] = y1; ey[2] = y2; ey[3] = y3; ey[4] = y4;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int waited;
    logic [W-1:0] hv, hw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1, "R1 reset in_ready", int'(in_ready), 1);
    chk(out_valid === 1'b0, "R1 reset out_valid", int'(out_valid), 0);

    // R10 lane order: leading pair in low bits; 0.6/0.8 angle
    set5(19661, 1000, -5000, 30000, 0, 26214, 2000, 7000, -30000, 12345);
    run_case("basic");
    // negative leading x
    set5(-20000, 3000, -3000, 100, 32767, 15000, -3000, 3000, -100, -32768);
    run_case("negx");
    // x(1) = 0: pure quarter turn
    set5(0, 1111, -2222, 3333, -4444, 12000, 5555, -6666, 7777, -8888);
    run_case("xzero");
    // tiny leading pair: deep normalisation
    set5(3, 20000, -20000, 500, -500, 4, 10000, 10000, -700, 700);
    run_case("tiny");
    // R7: 45 degrees with full-scale lanes
    set5(23170, 32767, -32768, 32767, -32768, 23170, 32767, -32768, -32768, 32767);
    run_case("sat45");
    // magnitude above one: v(1) clamps
    set5(-32768, 100, 200, 300, 400, -32768, -100, -200, -300, -400);
    run_case("bigmag");
    // R8: zero leading pair bypass
    set5(0, 12345, -32768, 32767, -1, 0, -54, 999, -7, 32000);
    run_case("zero");
    // pseudo-random vectors
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < VEC_LEN; i++) begin
        ex[i] = next_val(); ey[i] = next_val();
      end
      run_case("rand");
    end

    // R2: offers while busy are ignored
    set5(10000, -1234, 4321, 8000, -8000, -7000, 2222, -3333, 16000, 100);
    send();
    for (int j = 0; j < 3; j++) begin
      in_x = ~in_x; in_y = in_y ^ {W{1'b1}};
      in_valid = 1'b1;
      @(negedge clk);
    end
    in_valid = 1'b0;
    wait_out(waited);
    check_result("R2 busy ignore");
    take();

    // R9: back-pressure holds the result
    set5(5000, 1, 2, 3, 4, 9000, 5, 6, 7, 8);
    send();
    wait_out(waited);
    hv = out_v; hw = out_w;
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      chk(out_valid && out_v == hv && out_w == hw, "R9 hold", int'(out_valid), 1);
    end
    check_result("R9 held");
    take();
    chk(in_ready === 1'b1, "R9 release", int'(in_ready), 1);

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule